// File: doc/BRIEF.md
# Handheld Console Memory-Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the storage of a handheld games console. For each read or write it picks one target: cartridge ROM, the cartridge bank controller, video RAM, external cartridge RAM, work RAM, the sprite attribute table, IO registers, high RAM or the interrupt-enable register. Accesses that must not reach any storage go to a null target. The memories, the bank controller and the IO registers sit outside the block. The block drives their select lines and work-RAM bank number and gathers their read data.

Access is gated in three ways. The current video mode can lock the CPU out of video RAM and the sprite table. The cartridge size caps readable ROM. While a sprite-table DMA runs, the CPU is kept off any bus the DMA is using. The bus of each 8 KiB slice is set by a small table, and one entry of that table changes with the colour-model flag. Read data is registered and returned one clock after the address.

Top module: `mem_map_decoder`

## Requirements
- R1: A read with no gating active selects a target by address. The target codes and select bit positions are: bit 1 ROM for 0x0000–0x7FFF, bit 3 video RAM for 0x8000–0x9FFF, bit 4 external RAM for 0xA000–0xBFFF, bit 5 work RAM for 0xC000–0xFDFF, bit 6 sprite table for 0xFE00–0xFE9F, bit 7 IO for 0xFF00–0xFF7F, bit 8 high RAM for 0xFF80–0xFFFE, and bit 9 interrupt enable for 0xFFFF. Bit 0 is the null target and bit 2 the bank controller.
- R2: On every cycle with rd_i or wr_i high, exactly one bit of tgt_sel_o is set. On idle cycles tgt_sel_o is zero.
- R3: A write anywhere in 0x0000–0x7FFF selects the bank controller (bit 2), never ROM.
- R4: A ROM read at an address greater than or equal to rom_size_i selects the null target and returns 0xFF.
- R5: wram_bank_o is 0 for 0xC000–0xCFFF and 0xE000–0xEFFF. For 0xD000–0xDFFF and 0xF000–0xFDFF it is the low 3 bits of wram_sel_i, with 0 replaced by 1.
- R6: When vid_mode_i is 3, video RAM accesses select the null target. Reads return 0xFF and writes are dropped.
- R7: Sprite table accesses pass only in video modes 0 and 1. In modes 2 and 3 they select the null target.
- R8: 0xFEA0–0xFEFF always selects the null target. Reads return 0xFF.
- R9: While dma_busy_i is high, an access is blocked when its slice (address bits 15:13) is on the same bus as the slice of dma_src_i, unless that bus is the CPU-internal one. Slices 0–3 and 5 are on the main bus, slice 4 on the video bus, and slice 7 is CPU-internal. Slice 6 is on the main bus when color_i is 0 and on a separate work-RAM bus when color_i is 1.
- R10: While dma_busy_i is high, every access to 0xFE00–0xFE9F is blocked, whatever the DMA source.
- R11: rdata_o is 0x00 after reset. One clock after a read it holds the selected source's data, or 0xFF for the null target, and it keeps that value through cycles without a read.
- R12: wr_o is high only for a write whose target is not the null target.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| vid_mode_i | input | 2 | Current video mode 0–3 |
| dma_busy_i | input | 1 | Sprite-table DMA in progress |
| dma_src_i | input | 16 | Current DMA source address |
| rom_size_i | input | 24 | Cartridge ROM size in bytes |
| color_i | input | 1 | Colour-model flag |
| wram_sel_i | input | 8 | Raw work-RAM bank select value |
| rom_rdata_i | input | 8 | ROM read data |
| vram_rdata_i | input | 8 | Video RAM read data |
| xram_rdata_i | input | 8 | External RAM read data |
| wram_rdata_i | input | 8 | Work RAM read data |
| oam_rdata_i | input | 8 | Sprite table read data |
| io_rdata_i | input | 8 | IO register read data |
| hram_rdata_i | input | 8 | High RAM read data |
| ie_rdata_i | input | 8 | Interrupt-enable read data |
| tgt_sel_o | output | 10 | One-hot target select |
| wram_bank_o | output | 3 | Work-RAM bank for this access |
| wr_o | output | 1 | Write accepted by a real target |
| rdata_o | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that the select stays one-hot. They also check that the unusable window, out-of-range ROM reads, video-mode lockouts and DMA sprite-table lockout never reach a real target, that wr_o never fires toward the null target, and that the switchable work-RAM bank is never zero. Only the bench scenarios show that each address lands on the right target and data source. The same goes for the exact bank values, for the bus-conflict table differing between models for slice 6, and for the read data arriving one clock late and then holding.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef enum logic [3:0] {
    TGT_NONE = 4'd0,
    TGT_ROM  = 4'd1,
    TGT_MBC  = 4'd2,
    TGT_VRAM = 4'd3,
    TGT_XRAM = 4'd4,
    TGT_WRAM = 4'd5,
    TGT_OAM  = 4'd6,
    TGT_IO   = 4'd7,
    TGT_HRAM = 4'd8,
    TGT_IE   = 4'd9
  } tgt_e;

  localparam int NUM_TGT = 10;

  typedef enum logic [1:0] {
    BUS_CPU  = 2'd0,
    BUS_MAIN = 2'd1,
    BUS_VID  = 2'd2,
    BUS_WRK  = 2'd3
  } bus_e;

  function automatic bus_e slice_bus(input logic [2:0] slice, input logic color);
    case (slice)
      3'd4:    return BUS_VID;
      3'd6:    return color ? BUS_WRK : BUS_MAIN;
      3'd7:    return BUS_CPU;
      default: return BUS_MAIN;
    endcase
  endfunction
endpackage

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
  import mmd_pkg::*;
#(
  parameter int AW         = 16,
  parameter int BANK_SEL_W = 8,
  parameter int BANK_W     = 3
) (
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_i,
  input  logic [BANK_SEL_W-1:0] bank_sel_i,
  output tgt_e                  region_o,
  output logic [BANK_W-1:0]     bank_o
);
  logic [BANK_W-1:0] sw_bank;
  logic              unused_sel;

  assign unused_sel = ^bank_sel_i[BANK_SEL_W-1:BANK_W];
  assign sw_bank    = (bank_sel_i[BANK_W-1:0] == '0) ? BANK_W'(1) : bank_sel_i[BANK_W-1:0];
  // bit 12 splits fixed bank (C/E) from switchable bank (D/F)
  assign bank_o     = addr_i[AW-4] ? sw_bank : '0;

  always_comb begin
    region_o = TGT_NONE;
    if (!addr_i[AW-1]) begin
      region_o = wr_i ? TGT_MBC : TGT_ROM;
    end else begin
      case (addr_i[AW-2:AW-3])
        2'b00: region_o = TGT_VRAM;
        2'b01: region_o = TGT_XRAM;
        2'b10: region_o = TGT_WRAM;
        default: begin
          if (addr_i[AW-4:9] != '1)        region_o = TGT_WRAM;
          else if (!addr_i[8])             region_o = (addr_i[7:0] < 8'hA0) ? TGT_OAM : TGT_NONE;
          else if (!addr_i[7])             region_o = TGT_IO;
          else if (addr_i[6:0] == 7'h7F)   region_o = TGT_IE;
          else                             region_o = TGT_HRAM;
        end
      endcase
    end
  end
endmodule

// File: rtl/mmd_access_gate.sv
module mmd_access_gate
  import mmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int ROM_SZ_W = 24
) (
  input  logic [AW-1:0]       addr_i,
  input  tgt_e                region_i,
  input  logic [1:0]          vid_mode_i,
  input  logic                dma_busy_i,
  input  logic [AW-1:0]       dma_src_i,
  input  logic                color_i,
  input  logic [ROM_SZ_W-1:0] rom_size_i,
  output tgt_e                tgt_o
);
  bus_e dma_bus, acc_bus;
  logic dma_blk, rom_oob;

  assign dma_bus = slice_bus(dma_src_i[AW-1:AW-3], color_i);
  assign acc_bus = slice_bus(addr_i[AW-1:AW-3], color_i);
  assign dma_blk = dma_busy_i &&
                   (((dma_bus != BUS_CPU) && (dma_bus == acc_bus)) || (region_i == TGT_OAM));
  assign rom_oob = ROM_SZ_W'(addr_i) >= rom_size_i;

  always_comb begin
    tgt_o = region_i;
    if (dma_blk) begin
      tgt_o = TGT_NONE;
    end else begin
      case (region_i)
        TGT_VRAM: if (vid_mode_i == 2'd3) tgt_o = TGT_NONE;
        TGT_OAM:  if (vid_mode_i[1])      tgt_o = TGT_NONE;
        TGT_ROM:  if (rom_oob)            tgt_o = TGT_NONE;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mmd_read_path.sv
module mmd_read_path
  import mmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  tgt_e                           tgt_i,
  input  logic [NUM_TGT-1:0][DW-1:0]     src_i,
  output logic [DW-1:0]                  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= src_i[tgt_i];
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int ROM_SZ_W   = 24,
  parameter int BANK_SEL_W = 8,
  parameter int BANK_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [1:0]            vid_mode_i,
  input  logic                  dma_busy_i,
  input  logic [AW-1:0]         dma_src_i,
  input  logic [ROM_SZ_W-1:0]   rom_size_i,
  input  logic                  color_i,
  input  logic [BANK_SEL_W-1:0] wram_sel_i,
  input  logic [DW-1:0]         rom_rdata_i,
  input  logic [DW-1:0]         vram_rdata_i,
  input  logic [DW-1:0]         xram_rdata_i,
  input  logic [DW-1:0]         wram_rdata_i,
  input  logic [DW-1:0]         oam_rdata_i,
  input  logic [DW-1:0]         io_rdata_i,
  input  logic [DW-1:0]         hram_rdata_i,
  input  logic [DW-1:0]         ie_rdata_i,
  output logic [NUM_TGT-1:0]    tgt_sel_o,
  output logic [BANK_W-1:0]     wram_bank_o,
  output logic                  wr_o,
  output logic [DW-1:0]         rdata_o
);
  tgt_e region, tgt;
  logic access;
  logic [NUM_TGT-1:0][DW-1:0] src_data;

  assign access = rd_i | wr_i;

  mmd_region_decode #(.AW(AW), .BANK_SEL_W(BANK_SEL_W), .BANK_W(BANK_W)) u_region (
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .bank_sel_i(wram_sel_i),
    .region_o  (region),
    .bank_o    (wram_bank_o)
  );

  mmd_access_gate #(.AW(AW), .ROM_SZ_W(ROM_SZ_W)) u_gate (
    .addr_i    (addr_i),
    .region_i  (region),
    .vid_mode_i(vid_mode_i),
    .dma_busy_i(dma_busy_i),
    .dma_src_i (dma_src_i),
    .color_i   (color_i),
    .rom_size_i(rom_size_i),
    .tgt_o     (tgt)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign tgt_sel_o[g] = access && (tgt == tgt_e'(g));
  end

  assign wr_o = wr_i && (tgt != TGT_NONE);

  assign src_data[TGT_NONE] = '1;
  assign src_data[TGT_ROM]  = rom_rdata_i;
  assign src_data[TGT_MBC]  = '1;
  assign src_data[TGT_VRAM] = vram_rdata_i;
  assign src_data[TGT_XRAM] = xram_rdata_i;
  assign src_data[TGT_WRAM] = wram_rdata_i;
  assign src_data[TGT_OAM]  = oam_rdata_i;
  assign src_data[TGT_IO]   = io_rdata_i;
  assign src_data[TGT_HRAM] = hram_rdata_i;
  assign src_data[TGT_IE]   = ie_rdata_i;

  mmd_read_path #(.DW(DW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .tgt_i  (tgt),
    .src_i  (src_data),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker
  import mmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ROM_SZ_W = 24,
  parameter int BANK_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [1:0]          vid_mode_i,
  input logic                dma_busy_i,
  input logic [ROM_SZ_W-1:0] rom_size_i,
  input logic [NUM_TGT-1:0]  tgt_sel_o,
  input logic [BANK_W-1:0]   wram_bank_o,
  input logic                wr_o,
  input logic [DW-1:0]       rdata_o
);
  logic acc;
  assign acc = rd_i | wr_i;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> ($countones(tgt_sel_o) == 1));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (tgt_sel_o == '0));
  p_rom_oob_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !addr_i[AW-1] && (ROM_SZ_W'(addr_i) >= rom_size_i)) |-> tgt_sel_o[TGT_NONE]);
  p_sw_bank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o[TGT_WRAM] && addr_i[AW-4] |-> (wram_bank_o != '0));
  p_vram_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_mode_i == 2'd3) |-> !tgt_sel_o[TGT_VRAM]);
  p_oam_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o[TGT_OAM] |-> !vid_mode_i[1]);
  p_unusable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (addr_i >= AW'(16'hFEA0)) && (addr_i <= AW'(16'hFEFF))) |-> tgt_sel_o[TGT_NONE]);
  p_dma_oam_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_busy_i |-> !tgt_sel_o[TGT_OAM]);
  p_null_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && tgt_sel_o[TGT_NONE]) |=> (rdata_o == '1));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_wr_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (wr_i && !tgt_sel_o[TGT_NONE]));
endmodule

bind mem_map_decoder mmd_checker u_chk (.*);

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  import mmd_pkg::*;

  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] addr_i = 0, dma_src_i = 0;
  logic        rd_i = 0, wr_i = 0, dma_busy_i = 0, color_i = 0;
  logic [1:0]  vid_mode_i = 0;
  logic [23:0] rom_size_i = 24'h8000;
  logic [7:0]  wram_sel_i = 8'd1;
  logic [9:0]  tgt_sel_o;
  logic [2:0]  wram_bank_o;
  logic        wr_o;
  logic [7:0]  rdata_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  mem_map_decoder dut (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .vid_mode_i, .dma_busy_i, .dma_src_i,
    .rom_size_i, .color_i, .wram_sel_i,
    .rom_rdata_i(8'h11), .vram_rdata_i(8'h22), .xram_rdata_i(8'h33), .wram_rdata_i(8'h44),
    .oam_rdata_i(8'h55), .io_rdata_i(8'h66), .hram_rdata_i(8'h77), .ie_rdata_i(8'h88),
    .tgt_sel_o, .wram_bank_o, .wr_o, .rdata_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [15:0] a, input int t, input logic [7:0] d, input string req);
    @(negedge clk_i); addr_i = a; rd_i = 1; wr_i = 0;
    #1 chk({req, " sel"}, int'(tgt_sel_o), 1 << t);
    @(negedge clk_i); rd_i = 0;
    chk({req, " rdata"}, int'(rdata_o), int'(d));
  endtask

  task automatic wr_chk(input logic [15:0] a, input int t, input string req);
    @(negedge clk_i); addr_i = a; wr_i = 1; rd_i = 0;
    #1 chk({req, " sel"}, int'(tgt_sel_o), 1 << t);
    chk({req, " wr_o"}, int'(wr_o), (t != 0) ? 1 : 0);
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic bank_chk(input logic [15:0] a, input logic [7:0] s, input int b, input string req);
    @(negedge clk_i); addr_i = a; wram_sel_i = s; rd_i = 1;
    #1 chk({req, " bank"}, int'(wram_bank_o), b);
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset rdata", int'(rdata_o), 0);
    chk("R2 idle sel", int'(tgt_sel_o), 0);
  endtask

  task automatic t_routing;
    rd_chk(16'h0100, 1, 8'h11, "R1 rom");
    rd_chk(16'h8100, 3, 8'h22, "R1 vram");
    rd_chk(16'hA000, 4, 8'h33, "R1 xram");
    rd_chk(16'hC010, 5, 8'h44, "R1 wram");
    rd_chk(16'hFDFF, 5, 8'h44, "R1 wram mirror end");
    rd_chk(16'hFE10, 6, 8'h55, "R1 oam");
    rd_chk(16'hFF10, 7, 8'h66, "R1 io");
    rd_chk(16'hFF7F, 7, 8'h66, "R1 io end");
    rd_chk(16'hFF80, 8, 8'h77, "R1 hram");
    rd_chk(16'hFFFE, 8, 8'h77, "R1 hram end");
    rd_chk(16'hFFFF, 9, 8'h88, "R1 ie");
    @(negedge clk_i);
    chk("R11 hold", int'(rdata_o), 8'h88);
    chk("R2 idle", int'(tgt_sel_o), 0);
  endtask

  task automatic t_mbc;
    wr_chk(16'h2000, 2, "R3 mbc");
    wr_chk(16'h7FFF, 2, "R3 mbc top");
    wr_chk(16'hC000, 5, "R12 wram write");
  endtask

  task automatic t_romsize;
    rom_size_i = 24'h4000;
    rd_chk(16'h3FFF, 1, 8'h11, "R4 last byte");
    rd_chk(16'h4000, 0, 8'hFF, "R4 at size");
    rd_chk(16'h7FFF, 0, 8'hFF, "R4 beyond");
    rom_size_i = 24'h8000;
  endtask

  task automatic t_bank;
    bank_chk(16'hD000, 8'h00, 1, "R5 zero->1");
    bank_chk(16'hD123, 8'h05, 5, "R5 sel5");
    bank_chk(16'hDFFF, 8'h08, 1, "R5 low bits zero");
    bank_chk(16'hF000, 8'h0F, 7, "R5 mirror sel7");
    bank_chk(16'hC000, 8'h05, 0, "R5 fixed");
    bank_chk(16'hE800, 8'h05, 0, "R5 fixed mirror");
  endtask

  task automatic t_vmode;
    vid_mode_i = 2'd3;
    rd_chk(16'h8000, 0, 8'hFF, "R6 vram mode3");
    wr_chk(16'h9FFF, 0, "R6 vram write mode3");
    rd_chk(16'hFE00, 0, 8'hFF, "R7 oam mode3");
    vid_mode_i = 2'd2;
    rd_chk(16'h8000, 3, 8'h22, "R6 vram mode2");
    rd_chk(16'hFE9F, 0, 8'hFF, "R7 oam mode2");
    wr_chk(16'hFE00, 0, "R7 oam write mode2");
    vid_mode_i = 2'd1;
    rd_chk(16'hFE9F, 6, 8'h55, "R7 oam mode1");
    vid_mode_i = 2'd0;
    wr_chk(16'hFE00, 6, "R7 oam write mode0");
  endtask

  task automatic t_unusable;
    rd_chk(16'hFEA0, 0, 8'hFF, "R8 first");
    rd_chk(16'hFEFF, 0, 8'hFF, "R8 last");
    wr_chk(16'hFEC0, 0, "R8 write");
  endtask

  task automatic t_dma;
    dma_busy_i = 1; color_i = 0; dma_src_i = 16'hC000;
    rd_chk(16'h0100, 0, 8'hFF, "R9 mono rom blocked");
    rd_chk(16'hA000, 0, 8'hFF, "R9 mono xram blocked");
    rd_chk(16'hC000, 0, 8'hFF, "R9 mono wram blocked");
    rd_chk(16'h8000, 3, 8'h22, "R9 mono vram free");
    rd_chk(16'hFF80, 8, 8'h77, "R9 hram free");
    rd_chk(16'hFE00, 0, 8'hFF, "R10 oam blocked");
    color_i = 1;
    rd_chk(16'h0100, 1, 8'h11, "R9 color rom free");
    rd_chk(16'hD000, 0, 8'hFF, "R9 color wram blocked");
    rd_chk(16'hE000, 5, 8'h44, "R9 color slice7 free");
    dma_src_i = 16'h8000;
    rd_chk(16'h8800, 0, 8'hFF, "R9 vram src blocked");
    rd_chk(16'hC000, 5, 8'h44, "R9 vram src wram free");
    dma_src_i = 16'hE000;
    rd_chk(16'hC000, 5, 8'h44, "R9 cpu src no conflict");
    rd_chk(16'hFE50, 0, 8'hFF, "R10 oam cpu src");
    dma_src_i = 16'h0000;
    wr_chk(16'h2000, 0, "R9 mbc write dropped");
    dma_busy_i = 0; color_i = 0;
    rd_chk(16'hFE50, 6, 8'h55, "R10 oam after dma");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_routing();
    t_mbc();
    t_romsize();
    t_bank();
    t_vmode();
    t_unusable();
    t_dma();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule